// File: doc/BRIEF.md
# Program Correlation Message Generator

This block sits beside a processor's retirement stage inside an instruction trace unit. It keeps a running count of retired instructions and, when history recording is enabled, a bit string with one entry per direct branch (taken or not). When the core moves between its normal instruction encoding and its compressed encoding, the block closes the running segment and turns it into a correlation packet. A trace decoder can then read each count and history in the right encoding context.

A packet is assembled from a fixed header (message code, source ID, event code) followed by two variable-width fields: the instruction count and the branch history. Each is trimmed to its significant bits. The packet and its length in bits are offered to a downstream queue through a valid/ready pair. While the queue refuses a packet, the block holds it unchanged and raises a stall towards the core. A segment that would outgrow either field is closed early with its own event code.

Top module: `trace_corr_gen`

## Requirements
- R1: After reset no packet is offered, the stall output is low, the count is zero and the history holds no branch bits.
- R2: A retiring instruction that carries the page-crossing flag and whose mode differs from the previous retired instruction's mode produces a packet on the next clock edge, with event code 4'h4.
- R3: With history enabled, a retiring direct branch without the page-crossing flag whose mode differs from the previous one produces a packet with event code 4'h5. With history disabled, the same branch produces no packet.
- R4: A mode change with neither a page crossing nor a qualifying branch produces no packet. A page crossing without a mode change produces no packet.
- R5: Packet layout from bit 0 upward: 6-bit message code 6'b100001, then the 4-bit source ID, then the 4-bit event code, then the count field at bit 14, then the history field. All bits at and above the reported length are zero.
- R6: The count field equals the number of instructions accepted since the previous packet, including the instruction that triggered this one. Its width is the position of its highest set bit plus one, and never less than 1.
- R7: The history field is a 1 stop bit followed by one bit per direct branch accepted while history is enabled (1 = taken). The newest branch is at the field's bit 0 and the stop bit is the top bit of the packet. Branches accepted with history disabled add no bit.
- R8: The reported length equals 14 + count width + history width and always lies between 16 and 54.
- R9: Emitting a packet restarts the count at zero and the history at the bare stop bit. The triggering instruction belongs to the closed packet.
- R10: An accepted instruction that brings the count to 255, or the history to 31 branch bits, emits a packet with event code 4'hA. If the same instruction is also a mode switch, that switch's event code is used instead.
- R11: While a packet is offered and ready is low, the packet and its length stay unchanged, stall is high, and retiring instructions are ignored: they are neither counted, nor recorded, nor used for mode tracking.
- R12: If the offered packet is taken by the queue in the same cycle that a new trigger is accepted, the new packet replaces it at that edge without a gap cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | One instruction retires this cycle |
| br_valid_i | input | 1 | The retiring instruction is a direct branch |
| br_taken_i | input | 1 | Direct branch was taken |
| page_cross_i | input | 1 | The retiring instruction was reached by crossing a page boundary |
| mode_i | input | 1 | Encoding mode of the retiring instruction (1 = compressed) |
| hist_en_i | input | 1 | Branch history recording enabled |
| src_id_i | input | SRC_W | Source ID placed in the header |
| pkt_ready_i | input | 1 | Downstream queue accepts the packet |
| pkt_valid_o | output | 1 | Packet offered |
| pkt_data_o | output | DATA_W | Packet bits, LSB first |
| pkt_len_o | output | LEN_W | Packet length in bits |
| stall_o | output | 1 | Core must hold retirement |

## Verification
Two things can happen in one cycle: the queue takes the offered packet, and a new trigger is accepted. The bench holds ready low so that a packet stays pending, then raises ready at the same moment it drives a page-crossing mode switch. It then checks that valid never drops, that the data changes at once to the new packet's model value, and that exactly one transfer was counted at that edge. A second kind of coincidence is a mode switch on the very instruction that fills a field. The bench reaches it with a 254-instruction run ending in a switch, and with a 31-branch history ending in a branch switch. In both cases it judges that the switch's event code wins over the overflow code.

// File: rtl/trace_corr_pkg.sv
package trace_corr_pkg;

  localparam int TCODE_W = 6;
  localparam int EV_W    = 4;
  localparam logic [TCODE_W-1:0] CORR_TCODE = 6'b100001;

  typedef enum logic [EV_W-1:0] {
    EV_PAGE_SW   = 4'h4,
    EV_BRANCH_SW = 4'h5,
    EV_SEG_FULL  = 4'hA
  } corr_ev_e;

endpackage

// File: rtl/corr_mode_track.sv
module corr_mode_track (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic mode_i,
  input  logic page_cross_i,
  input  logic br_valid_i,
  input  logic hist_en_i,
  output logic sw_page,
  output logic sw_branch,
  output logic mode_q
);

  logic mode_diff;

  always_comb begin
    mode_diff = accept && (mode_i != mode_q);
    sw_page   = mode_diff && page_cross_i;
    sw_branch = mode_diff && !page_cross_i && br_valid_i && hist_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else if (accept) begin
      mode_q <= mode_i;
    end
  end

endmodule

// File: rtl/corr_segment.sv
module corr_segment #(
  parameter int ICNT_W = 8,
  parameter int HIST_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              br_rec,
  input  logic              br_taken,
  input  logic              restart,
  output logic [ICNT_W-1:0] icnt_q,
  output logic [ICNT_W-1:0] icnt_next,
  output logic [HIST_W-1:0] hist_q,
  output logic [HIST_W-1:0] hist_next,
  output logic              seg_full
);

  localparam logic [HIST_W-1:0] HIST_EMPTY = HIST_W'(1);

  logic icnt_at_max;
  logic hist_at_max;

  always_comb begin
    icnt_next   = icnt_q + ICNT_W'(1);
    hist_next   = br_rec ? {hist_q[HIST_W-2:0], br_taken} : hist_q;
    icnt_at_max = &icnt_next;
    hist_at_max = hist_next[HIST_W-1];
    seg_full    = accept && (icnt_at_max || hist_at_max);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt_q <= '0;
      hist_q <= HIST_EMPTY;
    end else if (restart) begin
      icnt_q <= '0;
      hist_q <= HIST_EMPTY;
    end else if (accept) begin
      icnt_q <= icnt_next;
      hist_q <= hist_next;
    end
  end

endmodule

// File: rtl/corr_packer.sv
module corr_packer #(
  parameter int ICNT_W = 8,
  parameter int HIST_W = 32,
  parameter int SRC_W  = 4,
  parameter int HDR_W  = 14,
  parameter int DATA_W = 54,
  parameter int LEN_W  = 6
) (
  input  logic [SRC_W-1:0]                src_id,
  input  trace_corr_pkg::corr_ev_e        evcode,
  input  logic [ICNT_W-1:0]               icnt,
  input  logic [HIST_W-1:0]               hist,
  output logic [DATA_W-1:0]               data,
  output logic [LEN_W-1:0]                len
);

  import trace_corr_pkg::*;

  function automatic int unsigned icnt_width(input logic [ICNT_W-1:0] v);
    int unsigned w;
    w = 1;
    for (int k = 0; k < ICNT_W; k++) begin
      if (v[k]) w = k + 1;
    end
    return w;
  endfunction

  function automatic int unsigned hist_width(input logic [HIST_W-1:0] v);
    int unsigned w;
    w = 1;
    for (int k = 0; k < HIST_W; k++) begin
      if (v[k]) w = k + 1;
    end
    return w;
  endfunction

  logic [HDR_W-1:0] header;
  int unsigned      iw;
  int unsigned      hw;

  always_comb begin
    header = {evcode, src_id, CORR_TCODE};
    iw     = icnt_width(icnt);
    hw     = hist_width(hist);
    data   = DATA_W'(header)
           | (DATA_W'(icnt) << HDR_W)
           | (DATA_W'(hist) << (HDR_W + iw));
    len    = LEN_W'(HDR_W + iw + hw);
  end

endmodule

// File: rtl/corr_out_stage.sv
module corr_out_stage #(
  parameter int DATA_W = 54,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  input  logic [LEN_W-1:0]  len_in,
  input  logic              ready,
  output logic              valid_q,
  output logic [DATA_W-1:0] data_q,
  output logic [LEN_W-1:0]  len_q,
  output logic              stall
);

  always_comb stall = valid_q && !ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      len_q   <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= data_in;
      len_q   <= len_in;
    end else if (ready) begin
      valid_q <= 1'b0;
    end
  end

endmodule

// File: rtl/trace_corr_gen.sv
module trace_corr_gen #(
  parameter int ICNT_W = 8,
  parameter int HIST_W = 32,
  parameter int SRC_W  = 4,
  localparam int HDR_W  = trace_corr_pkg::TCODE_W + SRC_W + trace_corr_pkg::EV_W,
  localparam int DATA_W = HDR_W + ICNT_W + HIST_W,
  localparam int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_i,
  input  logic              br_valid_i,
  input  logic              br_taken_i,
  input  logic              page_cross_i,
  input  logic              mode_i,
  input  logic              hist_en_i,
  input  logic [SRC_W-1:0]  src_id_i,
  input  logic              pkt_ready_i,
  output logic              pkt_valid_o,
  output logic [DATA_W-1:0] pkt_data_o,
  output logic [LEN_W-1:0]  pkt_len_o,
  output logic              stall_o
);

  import trace_corr_pkg::*;

  // Named internal events for the checker
  logic              accept_w;
  logic              br_rec_w;
  logic              sw_page_w;
  logic              sw_branch_w;
  logic              seg_full_w;
  logic              fire_w;
  logic              mode_w;
  corr_ev_e          ev_w;
  logic [ICNT_W-1:0] seg_icnt_w;
  logic [ICNT_W-1:0] icnt_next_w;
  logic [HIST_W-1:0] seg_hist_w;
  logic [HIST_W-1:0] hist_next_w;
  logic [DATA_W-1:0] pack_data_w;
  logic [LEN_W-1:0]  pack_len_w;

  always_comb begin
    accept_w = retire_i && !stall_o;
    br_rec_w = accept_w && br_valid_i && hist_en_i;
    fire_w   = sw_page_w || sw_branch_w || seg_full_w;
    if (sw_page_w)        ev_w = EV_PAGE_SW;
    else if (sw_branch_w) ev_w = EV_BRANCH_SW;
    else                  ev_w = EV_SEG_FULL;
  end

  corr_mode_track u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept_w),
    .mode_i       (mode_i),
    .page_cross_i (page_cross_i),
    .br_valid_i   (br_valid_i),
    .hist_en_i    (hist_en_i),
    .sw_page      (sw_page_w),
    .sw_branch    (sw_branch_w),
    .mode_q       (mode_w)
  );

  corr_segment #(.ICNT_W(ICNT_W), .HIST_W(HIST_W)) u_seg (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept_w),
    .br_rec    (br_rec_w),
    .br_taken  (br_taken_i),
    .restart   (fire_w),
    .icnt_q    (seg_icnt_w),
    .icnt_next (icnt_next_w),
    .hist_q    (seg_hist_w),
    .hist_next (hist_next_w),
    .seg_full  (seg_full_w)
  );

  corr_packer #(
    .ICNT_W(ICNT_W), .HIST_W(HIST_W), .SRC_W(SRC_W),
    .HDR_W(HDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)
  ) u_pack (
    .src_id (src_id_i),
    .evcode (ev_w),
    .icnt   (icnt_next_w),
    .hist   (hist_next_w),
    .data   (pack_data_w),
    .len    (pack_len_w)
  );

  corr_out_stage #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (fire_w),
    .data_in (pack_data_w),
    .len_in  (pack_len_w),
    .ready   (pkt_ready_i),
    .valid_q (pkt_valid_o),
    .data_q  (pkt_data_o),
    .len_q   (pkt_len_o),
    .stall   (stall_o)
  );

endmodule

// File: rtl/trace_corr_chk.sv
module trace_corr_chk #(
  parameter int ICNT_W = 8,
  parameter int HIST_W = 32,
  parameter int SRC_W  = 4,
  localparam int HDR_W  = trace_corr_pkg::TCODE_W + SRC_W + trace_corr_pkg::EV_W,
  localparam int DATA_W = HDR_W + ICNT_W + HIST_W,
  localparam int LEN_W  = $clog2(DATA_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pkt_valid_o,
  input logic              pkt_ready_i,
  input logic [DATA_W-1:0] pkt_data_o,
  input logic [LEN_W-1:0]  pkt_len_o,
  input logic              stall_o,
  input logic              fire_w,
  input logic [ICNT_W-1:0] seg_icnt_w,
  input logic [HIST_W-1:0] seg_hist_w
);

  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(HDR_W + 2);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(DATA_W);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid_o && !pkt_ready_i) |=> (pkt_valid_o && $stable(pkt_data_o) && $stable(pkt_len_o)));

  assert_stall_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> ($stable(seg_icnt_w) && $stable(seg_hist_w)));

  assert_len_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o |-> (pkt_len_o >= MIN_LEN && pkt_len_o <= MAX_LEN));

  assert_tcode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o |-> (pkt_data_o[5:0] == trace_corr_pkg::CORR_TCODE));

  assert_stop_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o |-> (pkt_data_o[pkt_len_o - LEN_W'(1)] == 1'b1 && (pkt_data_o >> pkt_len_o) == '0));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire_w |=> (seg_icnt_w == '0 && seg_hist_w == HIST_W'(1)));

  assert_fire_loads_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fire_w |=> pkt_valid_o);

  assert_icnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seg_icnt_w != '1);

endmodule

bind trace_corr_gen trace_corr_chk #(.ICNT_W(ICNT_W), .HIST_W(HIST_W), .SRC_W(SRC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pkt_valid_o (pkt_valid_o),
  .pkt_ready_i (pkt_ready_i),
  .pkt_data_o  (pkt_data_o),
  .pkt_len_o   (pkt_len_o),
  .stall_o     (stall_o),
  .fire_w      (fire_w),
  .seg_icnt_w  (seg_icnt_w),
  .seg_hist_w  (seg_hist_w)
);

// File: tb/tb_trace_corr_gen.sv
`timescale 1ns/1ps
module tb_trace_corr_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        retire_i, br_valid_i, br_taken_i, page_cross_i, mode_i, hist_en_i;
  logic [3:0]  src_id_i;
  logic        pkt_ready_i;
  logic        pkt_valid_o;
  logic [53:0] pkt_data_o;
  logic [5:0]  pkt_len_o;
  logic        stall_o;

  int checks = 0;
  int fails  = 0;
  int xfers  = 0;
  logic cur_mode = 1'b0;

  always #2.5 clk = ~clk;

  trace_corr_gen dut (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .br_valid_i(br_valid_i),
    .br_taken_i(br_taken_i), .page_cross_i(page_cross_i), .mode_i(mode_i),
    .hist_en_i(hist_en_i), .src_id_i(src_id_i), .pkt_ready_i(pkt_ready_i),
    .pkt_valid_o(pkt_valid_o), .pkt_data_o(pkt_data_o), .pkt_len_o(pkt_len_o),
    .stall_o(stall_o)
  );

  always @(posedge clk) if (rst_n && pkt_valid_o && pkt_ready_i) xfers++;

  // Vector: [51:48] expected event, [47:40] plain count, [39:34] branch count,
  // [33:2] taken pattern, [1] history enable, [0] trigger kind (1 = branch)
  localparam logic [51:0] VEC [8] = '{
    {4'h4, 8'd0,   6'd0,  32'h0000_0000, 1'b0, 1'b0},
    {4'h4, 8'd5,   6'd0,  32'h0000_0000, 1'b0, 1'b0},
    {4'h4, 8'd3,   6'd4,  32'h0000_000B, 1'b1, 1'b0},
    {4'h5, 8'd10,  6'd6,  32'h0000_0016, 1'b1, 1'b1},
    {4'h4, 8'd0,   6'd3,  32'h0000_0007, 1'b0, 1'b0},
    {4'h5, 8'd20,  6'd12, 32'h0000_0A5C, 1'b1, 1'b1},
    {4'h5, 8'd1,   6'd0,  32'h0000_0000, 1'b1, 1'b1},
    {4'h5, 8'd100, 6'd30, 32'h3333_3333, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic instr(input logic br, input logic tk, input logic pc, input logic md);
    retire_i = 1'b1; br_valid_i = br; br_taken_i = tk; page_cross_i = pc; mode_i = md;
    @(negedge clk);
    retire_i = 1'b0; br_valid_i = 1'b0; br_taken_i = 1'b0; page_cross_i = 1'b0;
  endtask

  task automatic idle();
    retire_i = 1'b0;
    @(negedge clk);
  endtask

  // Independent model: place fields bit by bit, LSB first
  task automatic model(input logic [3:0] ev, input logic [3:0] src, input int icnt,
                       input int nb, input logic [31:0] hv,
                       output logic [53:0] d, output int len);
    logic [5:0] tc;
    logic [63:0] hfull;
    int pos;
    int w;
    tc = 6'b100001;
    d = '0; pos = 0;
    for (int k = 0; k < 6; k++) begin d[pos] = tc[k]; pos++; end
    for (int k = 0; k < 4; k++) begin d[pos] = src[k]; pos++; end
    for (int k = 0; k < 4; k++) begin d[pos] = ev[k]; pos++; end
    w = 1;
    for (int k = 1; k < 8; k++) if (((icnt >> k) & 1) == 1) w = k + 1;
    for (int k = 0; k < w; k++) begin d[pos] = ((icnt >> k) & 1) == 1; pos++; end
    hfull = (64'd1 << nb) | 64'(hv);
    for (int k = 0; k <= nb; k++) begin d[pos] = hfull[k]; pos++; end
    len = pos;
  endtask

  task automatic expect_pkt(input string req, input logic [3:0] ev, input int icnt,
                            input int nb, input logic [31:0] hv);
    logic [53:0] d;
    int len;
    model(ev, src_id_i, icnt, nb, hv, d, len);
    check({req, " valid"}, 64'(pkt_valid_o), 64'd1);
    check({req, " data"},  64'(pkt_data_o),  64'(d));
    check({req, " len"},   64'(pkt_len_o),   64'(len));
  endtask

  task automatic page_switch();
    cur_mode = ~cur_mode;
    instr(1'b0, 1'b0, 1'b1, cur_mode);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [51:0] v;
    logic [31:0] hv;
    logic [53:0] saved;
    int spur;
    int nb;
    int x0;
    rst_n = 1'b0; retire_i = 1'b0; br_valid_i = 1'b0; br_taken_i = 1'b0;
    page_cross_i = 1'b0; mode_i = 1'b0; hist_en_i = 1'b0; src_id_i = 4'h0;
    pkt_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 valid after reset", 64'(pkt_valid_o), 64'd0);
    check("R1 stall after reset", 64'(stall_o), 64'd0);

    // Table walk: R2 R3 R5 R6 R7 R8 R9 R10 (entry 7 hits switch and full together)
    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      src_id_i  = 4'(i + 3);
      hist_en_i = v[1];
      spur = 0; hv = '0; nb = 0;
      for (int k = 0; k < int'(v[47:40]); k++) begin
        instr(1'b0, 1'b0, 1'b0, cur_mode);
        if (pkt_valid_o) spur++;
      end
      for (int k = 0; k < int'(v[39:34]); k++) begin
        instr(1'b1, v[2 + k], 1'b0, cur_mode);
        if (pkt_valid_o) spur++;
        if (v[1]) begin hv = {hv[30:0], v[2 + k]}; nb++; end
      end
      cur_mode = ~cur_mode;
      if (v[0]) begin
        instr(1'b1, 1'b1, 1'b0, cur_mode);
        hv = {hv[30:0], 1'b1}; nb++;
      end else begin
        instr(1'b0, 1'b0, 1'b1, cur_mode);
      end
      check("R4 no packet before trigger", 64'(spur), 64'd0);
      expect_pkt("R2/R3 R5 R6 R7 R8 table", v[51:48],
                 int'(v[47:40]) + int'(v[39:34]) + 1, nb, hv);
    end
    idle();

    // R3: branch mode switch with history disabled gives no packet; R6 counts it
    hist_en_i = 1'b0; src_id_i = 4'h9;
    cur_mode = ~cur_mode;
    instr(1'b1, 1'b1, 1'b0, cur_mode);
    check("R3 no packet with history off", 64'(pkt_valid_o), 64'd0);
    page_switch();
    expect_pkt("R3 R6 following page switch", 4'h4, 2, 0, 32'h0);

    // R4: mode change without cause, page crossing without mode change
    cur_mode = ~cur_mode;
    instr(1'b0, 1'b0, 1'b0, cur_mode);
    check("R4 plain mode change", 64'(pkt_valid_o), 64'd0);
    instr(1'b0, 1'b0, 1'b1, cur_mode);
    check("R4 page cross same mode", 64'(pkt_valid_o), 64'd0);
    page_switch();
    expect_pkt("R4 R9 count after ignored events", 4'h4, 3, 0, 32'h0);

    // R10: count reaches 255
    spur = 0;
    for (int k = 0; k < 254; k++) begin
      instr(1'b0, 1'b0, 1'b0, cur_mode);
      if (pkt_valid_o) spur++;
    end
    check("R10 no early packet", 64'(spur), 64'd0);
    instr(1'b0, 1'b0, 1'b0, cur_mode);
    expect_pkt("R10 count full", 4'hA, 255, 0, 32'h0);

    // R10: switch on the filling instruction wins
    for (int k = 0; k < 254; k++) instr(1'b0, 1'b0, 1'b0, cur_mode);
    page_switch();
    expect_pkt("R10 switch priority", 4'h4, 255, 0, 32'h0);

    // R10 / R8: history full with 8-bit count gives maximum length 54
    hist_en_i = 1'b1; spur = 0; hv = '0;
    for (int k = 0; k < 200; k++) instr(1'b0, 1'b0, 1'b0, cur_mode);
    for (int k = 0; k < 31; k++) begin
      instr(1'b1, 1'(k % 2), 1'b0, cur_mode);
      hv = {hv[30:0], 1'(k % 2)};
      if (k < 30 && pkt_valid_o) spur++;
    end
    check("R10 no early history packet", 64'(spur), 64'd0);
    expect_pkt("R8 R10 history full", 4'hA, 231, 31, hv);
    check("R8 max length", 64'(pkt_len_o), 64'd54);
    hist_en_i = 1'b0;
    idle();

    // R11: back-pressure holds packet, stalls and ignores retires
    pkt_ready_i = 1'b0;
    page_switch();
    saved = pkt_data_o;
    expect_pkt("R11 pending packet", 4'h4, 1, 0, 32'h0);
    idle();
    check("R11 stall high", 64'(stall_o), 64'd1);
    instr(1'b0, 1'b0, 1'b1, ~cur_mode);
    instr(1'b0, 1'b0, 1'b0, cur_mode);
    instr(1'b1, 1'b1, 1'b0, cur_mode);
    check("R11 data held", 64'(pkt_data_o), 64'(saved));
    check("R11 still valid", 64'(pkt_valid_o), 64'd1);
    pkt_ready_i = 1'b1;
    idle();
    check("R11 released", 64'(pkt_valid_o), 64'd0);
    check("R11 stall low", 64'(stall_o), 64'd0);
    page_switch();
    expect_pkt("R11 stalled retires not counted", 4'h4, 1, 0, 32'h0);
    idle();

    // R12: handoff and new trigger in one cycle
    pkt_ready_i = 1'b0;
    src_id_i = 4'h2;
    instr(1'b0, 1'b0, 1'b0, cur_mode);
    page_switch();
    expect_pkt("R12 first packet", 4'h4, 2, 0, 32'h0);
    x0 = xfers;
    pkt_ready_i = 1'b1;
    src_id_i = 4'h7;
    page_switch();
    expect_pkt("R12 replaced packet", 4'h4, 1, 0, 32'h0);
    check("R12 one transfer", 64'(xfers - x0), 64'd1);
    idle();
    check("R12 second transfer", 64'(xfers - x0), 64'd2);
    check("R12 drained", 64'(pkt_valid_o), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule